// File: doc/BRIEF.md
# Raster Scan Timing Generator

This block produces the horizontal and vertical timing of a raster display from two packed 32-bit timing words. Each word holds four interval lengths. The horizontal lengths are in units of eight pixels, and the vertical lengths are in lines. The block drives the following outputs:

- the two sync outputs
- a display-enable output
- the current pixel and line counts
- a display row index, which is halved when line doubling is on
- a two-bit vertical phase code that software can poll to find the end of active video
- the frame base address and line offset used for scanout addressing

Software programs the block through a simple write port with a three-bit register address. Writes to the timing words, the frame base and the line offset go into staging copies. The staging copies move into the working copies only on the clock edge that ends a frame, so a change never tears a frame. Writes to the control word take effect at once. The control word holds the sync enables, the sync polarities, line doubling and video enable.

Top module: `crtc_timing_gen`

## Requirements
- R1: Horizontal word at address 0: active width in bits 7:0, back porch in bits 14:9, sync in bits 20:16, front porch in bits 23:21. Each field f gives (f+1)*8 pixels. `pixX` counts from 0 to the sum of the four lengths minus one, then wraps to 0.
- R2: Vertical word at address 1: active lines in bits 10:0, back porch in bits 16:11, sync in bits 19:17, front porch in bits 25:20. Each field f gives f+1 lines. `lineY` advances when `pixX` wraps and returns to 0 after the last line.
- R3: Within a line the order is active, then front porch, then sync, then back porch. Frames follow the same order in lines.
- R4: `vState` encodes the vertical phase of `lineY`: 0 active, 1 front porch, 2 sync, 3 back porch.
- R5: Control word at address 2: bit 0 hsync enable, bit 1 vsync enable, bit 2 hsync active-high, bit 3 vsync active-high, bit 4 line double, bit 5 video enable. During its sync interval an enabled sync output drives the active level given by its polarity bit. Otherwise it drives the opposite level.
- R6: A sync output whose enable bit is 0 holds its inactive level for the whole frame.
- R7: `de` is 1 exactly when both counters are in their active intervals and video enable is 1.
- R8: `rowIdx` equals `lineY` when line doubling is off. When it is on, `rowIdx` equals `lineY` shifted right by one, so each row is shown on two scan lines.
- R9: A write to a timing word does not alter the frame in progress. It applies from the first pixel of the next frame.
- R10: The frame base (address 3) and the line offset (address 4, low 16 bits) appear on `frameBase` and `lineOffset` only from the start of the next frame.
- R11: After reset the counters are 0, all timing fields are 0 (32 pixels by 4 lines), the control word is 0 so both syncs are high and `de` is low, and the base and offset are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| pixX | output | 12 | Pixel count within the line |
| lineY | output | 12 | Line count within the frame |
| rowIdx | output | 12 | Displayed row index after line doubling |
| vState | output | 2 | Vertical phase code |
| frameBase | output | BASE_W | Frame base address in use |
| lineOffset | output | OFFS_W | Line offset in use |

## Verification
The outputs are combinational decodes of the counters, so every output reflects the counter state at the negative edge that follows each rising edge. A write to the control word shows on the syncs, `de` and `rowIdx` at the negative edge right after the edge that captures it. Shadowed values stay unchanged until the negative edge where `pixX` and `lineY` first read 0 after the write.

The bench writes a register and then waits one full cycle before it looks for the next frame start. This rules out a write that lands on the same edge as the frame wrap. From that point the bench predicts every output of every cycle from the cycle index alone, taking it modulo the line length and the frame length.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int CNT_W  = 12;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_HORZ = 3'd0;
  localparam logic [ADDR_W-1:0] A_VERT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_BASE = 3'd3;
  localparam logic [ADDR_W-1:0] A_OFFS = 3'd4;

  typedef struct packed {
    logic [2:0] fp;
    logic [4:0] sync;
    logic [5:0] bp;
    logic [7:0] act;
  } hField_t;

  typedef struct packed {
    logic [5:0]  fp;
    logic [2:0]  sync;
    logic [5:0]  bp;
    logic [10:0] act;
  } vField_t;

  // cumulative interval end points along one axis
  typedef struct packed {
    logic [CNT_W-1:0] actEnd;
    logic [CNT_W-1:0] fpEnd;
    logic [CNT_W-1:0] syncEnd;
    logic [CNT_W-1:0] total;
  } bounds_t;

  typedef struct packed {
    logic videoEn;
    logic lineDbl;
    logic vsHigh;
    logic hsHigh;
    logic vsEn;
    logic hsEn;
  } ctrl_t;

  typedef struct packed {
    logic lineWrap;
    logic frameWrap;
  } strobe_t;

  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } phase_t;
endpackage

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  strobe_t           strobe,
  output bounds_t           hB,
  output bounds_t           vB,
  output ctrl_t             ctrl,
  output logic [BASE_W-1:0] baseLive,
  output logic [OFFS_W-1:0] offsLive
);
  hField_t hStage, hLive;
  vField_t vStage, vLive;
  logic [BASE_W-1:0] baseStage;
  logic [OFFS_W-1:0] offsStage;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hStage <= '0; vStage <= '0; ctrl <= '0;
      baseStage <= '0; offsStage <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_HORZ: hStage <= '{fp: wrData[23:21], sync: wrData[20:16],
                            bp: wrData[14:9], act: wrData[7:0]};
        A_VERT: vStage <= '{fp: wrData[25:20], sync: wrData[19:17],
                            bp: wrData[16:11], act: wrData[10:0]};
        A_CTRL: ctrl <= ctrl_t'(wrData[5:0]);
        A_BASE: baseStage <= wrData[BASE_W-1:0];
        A_OFFS: offsStage <= wrData[OFFS_W-1:0];
        default: ;
      endcase
    end
  end

  // working copies move only on the frame-ending edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hLive <= '0; vLive <= '0; baseLive <= '0; offsLive <= '0;
    end else if (strobe.frameWrap) begin
      hLive <= hStage; vLive <= vStage;
      baseLive <= baseStage; offsLive <= offsStage;
    end
  end

  logic [CNT_W-1:0] hAct, hFp, hSy, hBp, vAct, vFp, vSy, vBp;
  always_comb begin
    hAct = (CNT_W'(hLive.act)  + CNT_W'(1)) << 3;
    hFp  = (CNT_W'(hLive.fp)   + CNT_W'(1)) << 3;
    hSy  = (CNT_W'(hLive.sync) + CNT_W'(1)) << 3;
    hBp  = (CNT_W'(hLive.bp)   + CNT_W'(1)) << 3;
    vAct = CNT_W'(vLive.act)  + CNT_W'(1);
    vFp  = CNT_W'(vLive.fp)   + CNT_W'(1);
    vSy  = CNT_W'(vLive.sync) + CNT_W'(1);
    vBp  = CNT_W'(vLive.bp)   + CNT_W'(1);
    hB.actEnd  = hAct;
    hB.fpEnd   = hAct + hFp;
    hB.syncEnd = hAct + hFp + hSy;
    hB.total   = hAct + hFp + hSy + hBp;
    vB.actEnd  = vAct;
    vB.fpEnd   = vAct + vFp;
    vB.syncEnd = vAct + vFp + vSy;
    vB.total   = vAct + vFp + vSy + vBp;
  end

  assert_hold_timing_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.frameWrap |=> ($stable(hLive) && $stable(vLive)));
  assert_hold_base_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.frameWrap |=> ($stable(baseLive) && $stable(offsLive)));
endmodule

// File: rtl/crtc_scan.sv
module crtc_scan
  import crtc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  bounds_t          hB,
  input  bounds_t          vB,
  output logic [CNT_W-1:0] hCnt,
  output logic [CNT_W-1:0] vCnt,
  output phase_t           hPh,
  output phase_t           vPh,
  output strobe_t          strobe
);
  function automatic phase_t phaseOf(input logic [CNT_W-1:0] c, input bounds_t b);
    if (c < b.actEnd)       return PH_ACT;
    else if (c < b.fpEnd)   return PH_FP;
    else if (c < b.syncEnd) return PH_SYNC;
    else                    return PH_BP;
  endfunction

  always_comb begin
    strobe.lineWrap  = (hCnt == hB.total - CNT_W'(1));
    strobe.frameWrap = strobe.lineWrap && (vCnt == vB.total - CNT_W'(1));
    hPh = phaseOf(hCnt, hB);
    vPh = phaseOf(vCnt, vB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else begin
      hCnt <= strobe.lineWrap ? '0 : hCnt + CNT_W'(1);
      if (strobe.frameWrap)     vCnt <= '0;
      else if (strobe.lineWrap) vCnt <= vCnt + CNT_W'(1);
    end
  end

  assert_hstep_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lineWrap |=> (hCnt == $past(hCnt) + CNT_W'(1)));
  assert_hwrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineWrap |=> (hCnt == '0));
  assert_vstep_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lineWrap && !strobe.frameWrap) |=> (vCnt == $past(vCnt) + CNT_W'(1)));
  assert_vstate_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lineWrap |=> $stable(vPh));
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [31:0]       wrData,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [11:0]       pixX,
  output logic [11:0]       lineY,
  output logic [11:0]       rowIdx,
  output logic [1:0]        vState,
  output logic [BASE_W-1:0] frameBase,
  output logic [OFFS_W-1:0] lineOffset
);
  bounds_t hB, vB;
  ctrl_t   ctrl;
  strobe_t strobe;
  phase_t  hPh, vPh;
  logic [CNT_W-1:0] hCnt, vCnt;

  crtc_regs #(.BASE_W(BASE_W), .OFFS_W(OFFS_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .hB(hB), .vB(vB), .ctrl(ctrl),
    .baseLive(frameBase), .offsLive(lineOffset)
  );

  crtc_scan uScan (
    .clk(clk), .rstN(rstN), .hB(hB), .vB(vB),
    .hCnt(hCnt), .vCnt(vCnt), .hPh(hPh), .vPh(vPh), .strobe(strobe)
  );

  logic hInSync, vInSync;
  always_comb begin
    hInSync = ctrl.hsEn && (hPh == PH_SYNC);
    vInSync = ctrl.vsEn && (vPh == PH_SYNC);
    hsync   = ctrl.hsHigh ? hInSync : !hInSync;
    vsync   = ctrl.vsHigh ? vInSync : !vInSync;
    de      = ctrl.videoEn && (hPh == PH_ACT) && (vPh == PH_ACT);
    pixX    = hCnt;
    lineY   = vCnt;
    rowIdx  = ctrl.lineDbl ? (vCnt >> 1) : vCnt;
    vState  = vPh;
  end
endmodule

// File: tb/tb_crtc_timing_gen.sv
module tb_crtc_timing_gen;
  logic clk = 0, rstN = 0, wrEn = 0;
  logic [2:0] wrAddr = 0;
  logic [31:0] wrData = 0;
  logic hsync, vsync, de;
  logic [11:0] pixX, lineY, rowIdx;
  logic [1:0] vState;
  logic [31:0] frameBase;
  logic [15:0] lineOffset;

  crtc_timing_gen dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .hsync(hsync), .vsync(vsync), .de(de), .pixX(pixX),
    .lineY(lineY), .rowIdx(rowIdx), .vState(vState), .frameBase(frameBase),
    .lineOffset(lineOffset));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  // expected configuration: lengths in pixels / lines
  int hA, hF, hS, hP, vA, vF, vS, vP;
  logic [5:0] eCtrl;
  int eBase, eOffs;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  function automatic int phaseOf(int c, int a, int f, int s);
    if (c < a) return 0;
    if (c < a + f) return 1;
    if (c < a + f + s) return 2;
    return 3;
  endfunction

  // horizontal word: act[7:0] bp[14:9] sync[20:16] fp[23:21], units of 8 px minus one
  task automatic setH(int ac, int fp, int sy, int bp);
    wr(3'd0, (ac) | (bp << 9) | (sy << 16) | (fp << 21));
  endtask
  task automatic expectH(int ac, int fp, int sy, int bp);
    hA = (ac + 1) * 8; hF = (fp + 1) * 8; hS = (sy + 1) * 8; hP = (bp + 1) * 8;
  endtask
  // vertical word: act[10:0] bp[16:11] sync[19:17] fp[25:20], lines minus one
  task automatic setV(int ac, int fp, int sy, int bp);
    wr(3'd1, (ac) | (bp << 11) | (sy << 17) | (fp << 20));
  endtask
  task automatic expectV(int ac, int fp, int sy, int bp);
    vA = ac + 1; vF = fp + 1; vS = sy + 1; vP = bp + 1;
  endtask

  task automatic syncFrame();
    do @(negedge clk); while (!(pixX == 0 && lineY == 0));
  endtask

  // compare every output for cycles t0..t0+n-1 of the frame; current negedge is t0
  task automatic checkRange(string tag, int t0, int n);
    for (int i = 0; i < n; i++) begin
      int t = t0 + i;
      int hT = hA + hF + hS + hP;
      int vT = vA + vF + vS + vP;
      int x = t % hT;
      int y = (t / hT) % vT;
      int hp = phaseOf(x, hA, hF, hS);
      int vp = phaseOf(y, vA, vF, vS);
      int eh = eCtrl[0] && hp == 2;
      int ev = eCtrl[1] && vp == 2;
      chk({tag, " R1 pixX"}, pixX, x);
      chk({tag, " R2 lineY"}, lineY, y);
      chk({tag, " R4 vState"}, vState, vp);
      chk({tag, " R3/R5/R6 hsync"}, hsync, eCtrl[2] ? eh : !eh);
      chk({tag, " R3/R5/R6 vsync"}, vsync, eCtrl[3] ? ev : !ev);
      chk({tag, " R7 de"}, de, eCtrl[5] && hp == 0 && vp == 0);
      chk({tag, " R8 rowIdx"}, rowIdx, eCtrl[4] ? (y >> 1) : y);
      chk({tag, " R10 frameBase"}, frameBase, eBase);
      chk({tag, " R10 lineOffset"}, lineOffset, eOffs);
      @(negedge clk);
    end
  endtask

  task automatic checkFrames(string tag, int nf);
    checkRange(tag, 0, nf * (hA + hF + hS + hP) * (vA + vF + vS + vP));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R11: reset state
    chk("R11 pixX", pixX, 0); chk("R11 lineY", lineY, 0);
    chk("R11 hsync", hsync, 1); chk("R11 vsync", vsync, 1);
    chk("R11 de", de, 0); chk("R11 base", frameBase, 0);
    expectH(0, 0, 0, 0); expectV(0, 0, 0, 0);
    eCtrl = 0; eBase = 0; eOffs = 0;
    checkFrames("R11 defaults", 2);

    // configuration A with a near-exhaustive sweep of the control word
    setH(1, 0, 0, 1); setV(3, 0, 1, 0);
    @(negedge clk); syncFrame();
    expectH(1, 0, 0, 1); expectV(3, 0, 1, 0);
    for (int c = 0; c < 64; c++) begin
      wr(3'd2, c); eCtrl = c[5:0];
      @(negedge clk); syncFrame();
      checkFrames("sweepA", 1);
    end

    // configuration B
    setH(3, 2, 1, 0); setV(5, 1, 0, 2);
    @(negedge clk); syncFrame();
    expectH(3, 2, 1, 0); expectV(5, 1, 0, 2);
    foreach (eCtrl[i]) ;
    for (int k = 0; k < 3; k++) begin
      logic [5:0] cv;
      cv = (k == 0) ? 6'b111111 : (k == 1) ? 6'b010011 : 6'b101100;
      wr(3'd2, cv); eCtrl = cv;
      @(negedge clk); syncFrame();
      checkFrames("cfgB", 2);
    end

    // R9: horizontal word rewritten mid-frame keeps the old timing until the frame ends
    checkRange("R9 pre", 0, 100);
    setH(1, 0, 0, 1);
    checkRange("R9 old", 102, (hA + hF + hS + hP) * (vA + vF + vS + vP) - 102);
    expectH(1, 0, 0, 1);
    checkFrames("R9 new", 1);

    // R10: base and offset appear only at the next frame start
    checkRange("R10 pre", 0, 50);
    wr(3'd3, 32'hDEAD_BEE8);
    wr(3'd4, 32'h0001_2345);
    checkRange("R10 old", 54, (hA + hF + hS + hP) * (vA + vF + vS + vP) - 54);
    eBase = 32'hDEAD_BEE8; eOffs = 16'h2345;
    checkFrames("R10 new", 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule